// File: doc/BRIEF.md
# Sector Byte-Stream Cache

This block converts between a memory that moves 128-bit words and a serial storage data engine that moves one byte at a time. It holds exactly one wide word in a 16-byte cache register. In the word-to-byte direction it fetches the words of one 512-byte sector one at a time. It hands their bytes to the consumer over a ready/valid port, most significant byte lane first, and fetches the next word only after the last lane has been taken. In the byte-to-word direction it packs incoming bytes into the cache, starting at the top lane. When the sixteenth byte lands, it writes the full word back to memory.

A transfer begins with a single-cycle `start` pulse in idle, which carries a word base address and a direction. Word addresses then step from the base, one per word, for 32 words. The memory port is a request/valid handshake: the block holds `mem_req` with a stable address (and data for a write) until the memory answers with a one-cycle `mem_valid`. A one-cycle `done` pulse closes the transfer, and the block returns to idle.

Top module: `sector_byte_cache`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_req`, `tx_valid` and `rx_ready` are all 0.
- R2: A `start` pulse in idle with `start_dir`=0 (word-to-byte) makes the block raise `mem_req` with `mem_we`=0 and `mem_addr` equal to `start_base` in the next cycle.
- R3: In word-to-byte mode, the 16 bytes of each fetched word leave on `tx_data` in lane order. The first comes from bits 127:120 and the last from bits 7:0, so byte n of the sector is lane n mod 16 of word n/16.
- R4: `tx_valid` stays 0 while a word fetch is outstanding. A new fetch is requested only after the byte from bits 7:0 has been accepted.
- R5: A transfer issues exactly 32 memory requests, the i-th one at address `start_base`+i.
- R6: `done` is 1 for exactly one cycle. In word-to-byte mode this is the cycle after the 512th byte is accepted. In byte-to-word mode it is the cycle after the 32nd write-back is answered. `busy` is 0 in the following cycle.
- R7: In byte-to-word mode (`start_dir`=1), received byte 16i+k is written to bits [127-8k -: 8] of the word stored at `start_base`+i.
- R8: In the cycle after the 16th byte of a word is accepted, `mem_req`=1 with `mem_we`=1. `rx_ready` stays 0 until that write is answered.
- R9: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` stays 1 and `tx_data` is unchanged in the next cycle.
- R10: A `start` pulse while `busy`=1 has no effect: the base address, direction and request sequence of the running transfer are kept.
- R11: Each accepted `start` resets the lane and word counters, so back-to-back transfers in either direction each begin at lane 0 of word `start_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_dir | input | 1 | 0 = word-to-byte, 1 = byte-to-word |
| start_base | input | ADDR_W | Word address of the sector's first word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| mem_req | output | 1 | Memory request, held until answered |
| mem_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | WORD_W | Packed word for a write-back |
| mem_valid | input | 1 | One-cycle answer to the pending request |
| mem_rdata | input | WORD_W | Fetched word, valid with `mem_valid` |
| tx_data | output | BYTE_W | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_ready | input | 1 | Consumer takes the byte |
| rx_data | input | BYTE_W | Incoming byte |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_ready | output | 1 | Block can take a byte |

## Verification
The assertions rely on the memory answering only a pending request, with a single-cycle `mem_valid`. They also assume `start` is a pulse whose base leaves room for 32 words. The bench memory model raises `mem_valid` for one cycle, only while `mem_req` is high, after a latency of one to three cycles. Every base it uses keeps all 32 words inside its 256-word array. Byte-side inputs change only on falling edges, so the handshakes the assertions see are always settled.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_FETCH   = 3'd1,
      S_STREAM  = 3'd2,
      S_COLLECT = 3'd3,
      S_WBACK   = 3'd4,
      S_DONE    = 3'd5
   } sbc_state_e;

   typedef enum logic {
      DIR_TO_BYTES = 1'b0,
      DIR_TO_WORDS = 1'b1
   } sbc_dir_e;
endpackage

// File: rtl/sbc_word_addr.sv
module sbc_word_addr #(
   parameter int ADDR_W = 32,
   parameter int WORDS  = 32,
   localparam int WIDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr,
   output logic              last_word
);
   logic [ADDR_W-1:0] base_q;
   logic [WIDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         base_q <= base_in;
         idx_q  <= '0;
      end else if (adv) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

   assign addr      = base_q + ADDR_W'(idx_q);
   assign last_word = (idx_q == WIDX_W'(WORDS - 1));

   // R5: each advance moves the word index by exactly one
   p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/sbc_lane_mux.sv
module sbc_lane_mux #(
   parameter int WORD_W    = 128,
   parameter int BYTE_W    = 8,
   parameter int MUX_STYLE = 0,
   localparam int LANES = WORD_W / BYTE_W,
   localparam int PTR_W = $clog2(LANES)
) (
   input  logic [WORD_W-1:0] cache,
   input  logic [PTR_W-1:0]  ptr,
   output logic [BYTE_W-1:0] byte_out
);
   generate
      if (MUX_STYLE == 0) begin : g_partsel
         assign byte_out = cache[ptr*BYTE_W +: BYTE_W];
      end else begin : g_andor
         always_comb begin
            byte_out = '0;
            for (int i = 0; i < LANES; i++) begin
               if (ptr == PTR_W'(i)) byte_out = byte_out | cache[i*BYTE_W +: BYTE_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbc_lane_pack.sv
module sbc_lane_pack #(
   parameter int WORD_W = 128,
   parameter int BYTE_W = 8,
   localparam int LANES = WORD_W / BYTE_W,
   localparam int PTR_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_word,
   input  logic [WORD_W-1:0] word_in,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [WORD_W-1:0] cache
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cache <= '0;
      end else if (load_word) begin
         cache <= word_in;
      end else if (wr_en) begin
         cache[ptr*BYTE_W +: BYTE_W] <= byte_in;
      end
   end
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
   import sbc_pkg::*;
#(
   parameter int LANES = 16,
   localparam int PTR_W = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_dir,
   input  logic             mem_valid,
   input  logic             tx_ready,
   input  logic             rx_valid,
   input  logic             last_word,
   output logic [PTR_W-1:0] ptr,
   output logic             load_cfg,
   output logic             word_adv,
   output logic             cache_load,
   output logic             lane_wr,
   output logic             busy,
   output logic             done,
   output logic             mem_req,
   output logic             mem_we,
   output logic             tx_valid,
   output logic             rx_ready
);
   localparam logic [PTR_W-1:0] TOP_LANE = PTR_W'(LANES - 1);

   sbc_state_e state;
   logic       ptr_zero;

   assign ptr_zero = (ptr == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         ptr   <= TOP_LANE;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               ptr   <= TOP_LANE;
               state <= (start_dir == DIR_TO_WORDS) ? S_COLLECT : S_FETCH;
            end
            S_FETCH: if (mem_valid) begin
               ptr   <= TOP_LANE;
               state <= S_STREAM;
            end
            S_STREAM: if (tx_ready) begin
               if (ptr_zero) state <= last_word ? S_DONE : S_FETCH;
               else          ptr   <= ptr - 1'b1;
            end
            S_COLLECT: if (rx_valid) begin
               if (ptr_zero) state <= S_WBACK;
               else          ptr   <= ptr - 1'b1;
            end
            S_WBACK: if (mem_valid) begin
               if (last_word) state <= S_DONE;
               else begin
                  ptr   <= TOP_LANE;
                  state <= S_COLLECT;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign load_cfg   = (state == S_IDLE) && start;
   assign cache_load = (state == S_FETCH) && mem_valid;
   assign lane_wr    = (state == S_COLLECT) && rx_valid;
   assign word_adv   = !last_word &&
                       (((state == S_STREAM) && tx_ready && ptr_zero) ||
                        ((state == S_WBACK) && mem_valid));
   assign busy       = (state != S_IDLE);
   assign done       = (state == S_DONE);
   assign mem_req    = (state == S_FETCH) || (state == S_WBACK);
   assign mem_we     = (state == S_WBACK);
   assign tx_valid   = (state == S_STREAM);
   assign rx_ready   = (state == S_COLLECT);

   // R3: lane pointer steps down by one per accepted byte
   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (((tx_valid && tx_ready) || (rx_ready && rx_valid)) && !ptr_zero)
         |=> (ptr == $past(ptr) - 1'b1));

   // R8: a full word is written back in the next cycle
   p_full_to_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && rx_valid && ptr_zero) |=> (mem_req && mem_we && !rx_ready));

   // R6: done is a single-cycle pulse followed by idle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
endmodule

// File: rtl/sector_byte_cache.sv
module sector_byte_cache #(
   parameter int ADDR_W       = 32,
   parameter int WORD_W       = 128,
   parameter int BYTE_W       = 8,
   parameter int SECTOR_BYTES = 512,
   parameter int MUX_STYLE    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_dir,
   input  logic [ADDR_W-1:0] start_base,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_valid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready
);
   localparam int LANES = WORD_W / BYTE_W;
   localparam int WORDS = SECTOR_BYTES / LANES;
   localparam int PTR_W = $clog2(LANES);

   generate
      if ((WORD_W % BYTE_W) != 0 || (LANES & (LANES - 1)) != 0 || LANES < 2) begin : g_bad_lanes
         $error("sector_byte_cache: WORD_W must hold a power-of-two number (>=2) of bytes");
      end
      if ((SECTOR_BYTES % LANES) != 0 || WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("sector_byte_cache: SECTOR_BYTES must be a power-of-two multiple (>=2) of the word");
      end
   endgenerate

   logic [PTR_W-1:0]  ptr;
   logic              load_cfg, word_adv, cache_load, lane_wr, last_word;
   logic [WORD_W-1:0] cache;

   sbc_ctrl #(.LANES(LANES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_dir  (start_dir),
      .mem_valid  (mem_valid),
      .tx_ready   (tx_ready),
      .rx_valid   (rx_valid),
      .last_word  (last_word),
      .ptr        (ptr),
      .load_cfg   (load_cfg),
      .word_adv   (word_adv),
      .cache_load (cache_load),
      .lane_wr    (lane_wr),
      .busy       (busy),
      .done       (done),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .tx_valid   (tx_valid),
      .rx_ready   (rx_ready)
   );

   sbc_word_addr #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_cfg),
      .base_in   (start_base),
      .adv       (word_adv),
      .addr      (mem_addr),
      .last_word (last_word)
   );

   sbc_lane_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_word (cache_load),
      .word_in   (mem_rdata),
      .wr_en     (lane_wr),
      .ptr       (ptr),
      .byte_in   (rx_data),
      .cache     (cache)
   );

   sbc_lane_mux #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .MUX_STYLE(MUX_STYLE)) u_mux (
      .cache    (cache),
      .ptr      (ptr),
      .byte_out (tx_data)
   );

   assign mem_wdata = cache;

   // R9: a stalled byte is held
   p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   // R4: no byte is offered while a fetch is outstanding
   p_fetch_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !tx_valid);

   // R10: start during a transfer leaves the address alone
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !word_adv) |=> $stable(mem_addr));

   // R5: the address holds while a request waits for its answer
   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/sector_byte_cache_tb.sv
`timescale 1ns/1ps
module sector_byte_cache_tb;
   localparam int ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              start_dir = 1'b0;
   logic [ADDR_W-1:0] start_base = '0;
   logic              busy, done, mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [127:0]      mem_wdata;
   logic              mem_valid = 1'b0;
   logic [127:0]      mem_rdata = '0;
   logic [7:0]        tx_data;
   logic              tx_valid;
   logic              tx_ready = 1'b0;
   logic [7:0]        rx_data = '0;
   logic              rx_valid = 1'b0;
   logic              rx_ready;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic [127:0] mem [0:255];
   logic [ADDR_W-1:0] addr_log [0:63];
   int log_n = 0;
   int wait_cnt = 1;

   always #2.5 clk = ~clk;

   sector_byte_cache u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
      .start_base(start_base), .busy(busy), .done(done), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready)
   );

   function automatic logic [7:0] pat(input int a, input int k);
      return 8'(a * 29 + k * 13 + 5);
   endfunction

   function automatic logic [7:0] pat2(input int n, input int seed);
      return 8'(n * 7 + seed * 31 + (n >> 4));
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: one-cycle answer after 1..3 cycles of latency
   always @(negedge clk) begin
      if (mem_valid) begin
         mem_valid = 1'b0;
      end else if (mem_req && rst_n) begin
         if (wait_cnt == 0) begin
            if (log_n < 64) addr_log[log_n] = mem_addr;
            log_n++;
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[7:0]];
            mem_valid = 1'b1;
            wait_cnt = (log_n % 3) + 1;
         end else begin
            wait_cnt--;
         end
      end
   end

   task automatic pulse_start(input logic dir, input logic [ADDR_W-1:0] base);
      @(negedge clk);
      start = 1'b1; start_dir = dir; start_base = base;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !tx_valid && !rx_ready, "R1 outputs in reset", {busy, done, mem_req, tx_valid, rx_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!busy && !done && !mem_req && !tx_valid && !rx_ready, "R1 outputs after reset", {busy, done, mem_req, tx_valid, rx_ready}, 0);
   endtask

   task automatic t_fetch(input int base, input bit stall, input bit inject);
      int got = 0;
      int cyc = 0;
      int bad4 = 0;
      bit hold = 1'b0;
      logic [7:0] held = '0;
      log_n = 0;
      @(negedge clk);
      start = 1'b1; start_dir = 1'b0; start_base = ADDR_W'(base);
      @(negedge clk); #1;
      start = 1'b0;
      chk(mem_req && !mem_we && mem_addr == ADDR_W'(base), "R2 first fetch request", mem_addr, base);
      while (got < 512 && cyc < 20000) begin
         if (cyc != 0) @(negedge clk);
         if (inject && cyc == 100) begin
            start = 1'b1; start_dir = 1'b1; start_base = ADDR_W'(base + 77);
         end else begin
            start = 1'b0;
         end
         tx_ready = stall ? ((cyc % 5) != 2 && (cyc % 7) != 3) : 1'b1;
         #1;
         if (hold) begin
            chk(tx_valid && tx_data == held, "R9 stalled byte held", tx_data, held);
         end
         hold = tx_valid && !tx_ready;
         held = tx_data;
         if (mem_req && !mem_we && tx_valid) bad4++;
         if (tx_valid && tx_ready) begin
            logic [7:0] e;
            e = pat(base + got / 16, got % 16);
            chk(tx_data == e, "R3 byte order", tx_data, e);
            got++;
         end
         cyc++;
      end
      start = 1'b0;
      chk(bad4 == 0, "R4 no byte during fetch", bad4, 0);
      chk(got == 512, "R3 sector length", got, 512);
      @(negedge clk); #1;
      tx_ready = 1'b0;
      chk(done && !mem_req, "R6 done after last byte", done, 1);
      @(negedge clk); #1;
      chk(!done && !busy, "R6 idle after done", {done, busy}, 0);
      chk(log_n == 32, "R5 request count", log_n, 32);
      for (int i = 0; i < 32; i++) begin
         chk(addr_log[i] == ADDR_W'(base + i), inject ? "R10 address kept" : "R5 address step",
             addr_log[i], base + i);
      end
   endtask

   task automatic t_pack(input int base, input bit gap, input int seed);
      int sent = 0;
      int cyc = 0;
      int bad8 = 0;
      log_n = 0;
      pulse_start(1'b1, ADDR_W'(base));
      while (sent < 512 && cyc < 20000) begin
         rx_valid = gap ? ((cyc % 3) != 1) : 1'b1;
         rx_data = pat2(sent, seed);
         #1;
         if (mem_req && rx_ready) bad8++;
         if (rx_valid && rx_ready) begin
            sent++;
            if (sent % 16 == 0) begin
               @(negedge clk);
               rx_valid = 1'b0;
               #1;
               chk(mem_req && mem_we && !rx_ready, "R8 write-back after 16th byte",
                   {mem_req, mem_we, rx_ready}, 3'b110);
            end
         end
         @(negedge clk);
         cyc++;
      end
      rx_valid = 1'b0;
      chk(bad8 == 0, "R8 rx_ready low during write-back", bad8, 0);
      cyc = 0;
      #1;
      while (!done && cyc < 50) begin
         @(negedge clk); #1;
         cyc++;
      end
      chk(done == 1'b1, "R6 done after last write-back", done, 1);
      @(negedge clk); #1;
      chk(!done && !busy, "R6 idle after pack", {done, busy}, 0);
      chk(log_n == 32, "R5 write-back count", log_n, 32);
      for (int i = 0; i < 32; i++) begin
         logic [127:0] w;
         for (int k = 0; k < 16; k++) w[127 - 8*k -: 8] = pat2(16*i + k, seed);
         chk(mem[8'(base + i)] == w, "R7 packed word", mem[8'(base + i)][63:0], w[63:0]);
         chk(addr_log[i] == ADDR_W'(base + i), "R5 write address", addr_log[i], base + i);
      end
   endtask

   initial begin
      for (int a = 0; a < 256; a++)
         for (int k = 0; k < 16; k++) mem[a][127 - 8*k -: 8] = pat(a, k);
      t_reset_state();
      t_fetch(16, 1'b0, 1'b0);
      t_fetch(128, 1'b1, 1'b1);
      t_pack(48, 1'b0, 1);
      t_pack(96, 1'b1, 9);
      // R11: back-to-back fetch of a plain region after packing restarts at lane 0
      t_fetch(160, 1'b1, 1'b0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule